// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block retires or retries one entry of a host controller's transfer schedule after a single bus transaction. It receives the entry's 32-bit control/status word, its 32-bit token word and a summary of what happened on the bus. The summary gives the number of bytes moved, the direction, and the handshake and error flags. One clock later the block returns the rewritten control/status word, together with single-cycle event pulses that the interrupt logic consumes: completion, error, short packet and a malformed token.

The block never touches memory, never moves payload data and never follows list links. A surrounding sequencer fetches the entry, runs the transaction, presents both words and the result with `in_valid`, and writes `out_ctrl` back when `out_valid` is high. Retries are accounted in a 2-bit error allowance inside the control/status word. A NAK costs nothing. Byte counts are stored with a minus-one encoding, so a count of zero bytes reads back as all ones.

Top module: `td_status_updater`

## Requirements
- R1: While reset is asserted and until the first accepted input, `out_valid`, `out_ctrl` and all four event outputs are zero.
- R2: If bit 23 (active) of `in_ctrl` is 0, `out_ctrl` equals `in_ctrl` and no event output is raised.
- R3: For an active entry, the token is malformed when its bits 7:0 are not 0x2D, 0x69 or 0xE1, or when its bits 31:21 (length code) are above 0x4FF and differ from 0x7FF. In that case `ev_token_bad` pulses, `out_ctrl` equals `in_ctrl`, and no other event is raised.
- R4: A clean transaction has no flag set. It clears bit 23, writes bits 10:0 with the byte count minus one modulo 2048 (0 bytes gives 0x7FF), and leaves every other bit unchanged.
- R5: `ev_done` pulses when an update clears bit 23 (whether by success or by a fault) and bit 24 (completion interrupt request) of `in_ctrl` is set.
- R6: `ev_short` pulses on a clean transaction whose `res_is_in` is 1, whose bit 29 (short-packet detect) is set, and whose byte count is below the expected count. The expected count is the token length code plus one, modulo 2048, so code 0x7FF expects 0 bytes.
- R7: A NAK sets bit 19 and leaves bit 23, the allowance in bits 28:27 and the length field unchanged, with no event.
- R8: A CRC/timeout flag sets bit 18 and a bitstuff flag sets bit 17. A nonzero allowance in bits 28:27 is decremented. If the allowance falls from 1 to 0, bit 22 is set, bit 23 is cleared and `ev_err` pulses. An allowance of 0 is left at 0 and the entry stays active without an event.
- R9: A stall handshake sets bit 22, babble sets bit 20 and a buffer error sets bit 21. Each of them clears bit 23 and pulses `ev_err`.
- R10: When several flags are present, only the first in the order stall, babble, buffer error, CRC/timeout or bitstuff, NAK is applied.
- R11: Results appear on the clock edge that samples `in_valid`. Events last one cycle, and `out_ctrl` holds its value while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Transaction result and descriptor words are present |
| in_ctrl | input | 32 | Control/status word before update |
| in_token | input | 32 | Token word of the same entry |
| res_nbytes | input | 11 | Bytes actually moved (plain count) |
| res_is_in | input | 1 | Transaction moved data toward the host |
| res_nak | input | 1 | Device answered NAK |
| res_stall | input | 1 | Device answered with a stall handshake |
| res_crc | input | 1 | CRC or timeout error |
| res_bitstuff | input | 1 | Bitstuff error |
| res_babble | input | 1 | Device sent more than allowed |
| res_buferr | input | 1 | Data buffer overrun or underrun |
| out_valid | output | 1 | `out_ctrl` and events belong to the input of the previous edge |
| out_ctrl | output | 32 | Updated control/status word |
| ev_done | output | 1 | Completion interrupt request |
| ev_err | output | 1 | Error retirement |
| ev_short | output | 1 | Short input packet |
| ev_token_bad | output | 1 | Malformed token rejected |

## Verification
Every decision of the block appears in the next cycle's `out_ctrl` and event pulses. A wrong priority, a missed decrement or a misplaced status bit therefore shows at the ports one clock after the transaction that caused it, with no later state to hide it. The allowance and the active bit are carried only by the word the block returns. So an error in the retry count becomes visible either in bits 28:27 of that same word or as a premature or missing `ev_err`. Random words and flag combinations are compared against an independent bench model, and directed cases cover the length wrap at zero, the 0x7FF length code, the allowance boundaries and the all-flags priority.

// File: rtl/td_pkg.sv
package td_pkg;
  localparam int CSW_W   = 32;
  localparam int LEN_W   = 11;
  localparam int ALLOW_W = 2;
  localparam int PID_W   = 8;

  // control/status word positions (decoded by the schedule sequencer)
  localparam int B_SPD    = 29;
  localparam int B_ALW_HI = 28;
  localparam int B_ALW_LO = 27;
  localparam int B_IOC    = 24;
  localparam int B_ACT    = 23;
  localparam int B_STALL  = 22;
  localparam int B_BUF    = 21;
  localparam int B_BAB    = 20;
  localparam int B_NAK    = 19;
  localparam int B_CRC    = 18;
  localparam int B_BSTF   = 17;

  // token word positions
  localparam int T_LEN_HI = 31;
  localparam int T_LEN_LO = 21;
  localparam int T_PID_HI = 7;
  localparam int T_PID_LO = 0;

  localparam logic [PID_W-1:0] PID_SETUP = 8'h2D;
  localparam logic [PID_W-1:0] PID_IN    = 8'h69;
  localparam logic [PID_W-1:0] PID_OUT   = 8'hE1;
  localparam logic [LEN_W-1:0] LEN_NULL  = '1;

  typedef struct packed {
    logic             is_in;
    logic             nak;
    logic             stall;
    logic             crc;
    logic             bitstuff;
    logic             babble;
    logic             buferr;
    logic [LEN_W-1:0] nbytes;
  } txn_res_t;

  typedef struct packed {
    logic done;
    logic err;
    logic short_pkt;
    logic token_bad;
  } td_evt_t;
endpackage

// File: rtl/td_rst_sync.sv
module td_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/td_token_check.sv
module td_token_check
  import td_pkg::*;
#(
  parameter logic [LEN_W-1:0] MAX_LEN_CODE = 11'h4FF
) (
  input  logic [CSW_W-1:0] token,
  output logic             token_ok,
  output logic [LEN_W-1:0] exp_bytes
);
  localparam int N_PID = 3;
  localparam logic [N_PID*PID_W-1:0] PID_LIST = {PID_SETUP, PID_IN, PID_OUT};

  logic [LEN_W-1:0] len_code;
  logic [PID_W-1:0] pid;
  logic [N_PID-1:0] pid_hit;
  logic             len_ok;
  logic             unused_tok_bits;

  assign len_code = token[T_LEN_HI:T_LEN_LO];
  assign pid      = token[T_PID_HI:T_PID_LO];
  assign unused_tok_bits = ^token[T_LEN_LO-1:T_PID_HI+1];

  for (genvar g = 0; g < N_PID; g++) begin : g_pid
    assign pid_hit[g] = (pid == PID_LIST[g*PID_W +: PID_W]);
  end

  assign len_ok    = (len_code <= MAX_LEN_CODE) || (len_code == LEN_NULL);
  assign token_ok  = (|pid_hit) && len_ok;
  // code n-1 -> n bytes; the all-ones code wraps to zero bytes
  assign exp_bytes = len_code + LEN_W'(1);
endmodule

// File: rtl/td_status_calc.sv
module td_status_calc
  import td_pkg::*;
(
  input  logic [CSW_W-1:0] ctrl,
  input  txn_res_t         res,
  input  logic             token_ok,
  input  logic [LEN_W-1:0] exp_bytes,
  output logic [CSW_W-1:0] nxt_ctrl,
  output td_evt_t          evt
);
  logic [ALLOW_W-1:0] allow;
  logic               fault_retire;
  logic               clean_retire;

  assign allow = ctrl[B_ALW_HI:B_ALW_LO];

  always_comb begin
    nxt_ctrl     = ctrl;
    evt          = '0;
    fault_retire = 1'b0;
    clean_retire = 1'b0;
    if (!ctrl[B_ACT]) begin
      nxt_ctrl = ctrl;
    end else if (!token_ok) begin
      evt.token_bad = 1'b1;
    end else if (res.stall) begin
      nxt_ctrl[B_STALL] = 1'b1;
      fault_retire      = 1'b1;
    end else if (res.babble) begin
      nxt_ctrl[B_BAB] = 1'b1;
      fault_retire    = 1'b1;
    end else if (res.buferr) begin
      nxt_ctrl[B_BUF] = 1'b1;
      fault_retire    = 1'b1;
    end else if (res.crc || res.bitstuff) begin
      if (res.crc)      nxt_ctrl[B_CRC]  = 1'b1;
      if (res.bitstuff) nxt_ctrl[B_BSTF] = 1'b1;
      if (allow != '0) begin
        nxt_ctrl[B_ALW_HI:B_ALW_LO] = allow - ALLOW_W'(1);
        if (allow == ALLOW_W'(1)) begin
          nxt_ctrl[B_STALL] = 1'b1;
          fault_retire      = 1'b1;
        end
      end
    end else if (res.nak) begin
      nxt_ctrl[B_NAK] = 1'b1;
    end else begin
      nxt_ctrl[LEN_W-1:0] = res.nbytes - LEN_W'(1);
      clean_retire        = 1'b1;
      evt.short_pkt       = res.is_in && ctrl[B_SPD] && (res.nbytes < exp_bytes);
    end
    if (fault_retire || clean_retire) nxt_ctrl[B_ACT] = 1'b0;
    evt.err  = fault_retire;
    evt.done = (fault_retire || clean_retire) && ctrl[B_IOC];
  end

  always_comb begin
    if (evt.token_bad) begin
      AST_TOKEN_NO_OTHER: assert (!evt.done && !evt.err && !evt.short_pkt); // R3
    end
    if (evt.short_pkt) begin
      AST_SHORT_ON_CLEAN: assert (!evt.err && !nxt_ctrl[B_ACT]); // R6
    end
  end
endmodule

// File: rtl/td_status_updater.sv
module td_status_updater
  import td_pkg::*;
#(
  parameter logic [LEN_W-1:0] MAX_LEN_CODE = 11'h4FF,
  parameter int               RST_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CSW_W-1:0] in_ctrl,
  input  logic [CSW_W-1:0] in_token,
  input  logic [LEN_W-1:0] res_nbytes,
  input  logic             res_is_in,
  input  logic             res_nak,
  input  logic             res_stall,
  input  logic             res_crc,
  input  logic             res_bitstuff,
  input  logic             res_babble,
  input  logic             res_buferr,
  output logic             out_valid,
  output logic [CSW_W-1:0] out_ctrl,
  output logic             ev_done,
  output logic             ev_err,
  output logic             ev_short,
  output logic             ev_token_bad
);
  logic             rst_sync_n;
  txn_res_t         res;
  logic             token_ok;
  logic [LEN_W-1:0] exp_bytes;
  logic [CSW_W-1:0] calc_ctrl;
  td_evt_t          calc_evt;

  logic             valid_d, valid_q;
  logic [CSW_W-1:0] ctrl_d, ctrl_q;
  td_evt_t          evt_d, evt_q;

  td_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  assign res = '{is_in: res_is_in, nak: res_nak, stall: res_stall, crc: res_crc,
                 bitstuff: res_bitstuff, babble: res_babble, buferr: res_buferr,
                 nbytes: res_nbytes};

  td_token_check #(.MAX_LEN_CODE(MAX_LEN_CODE)) i_token_check (
    .token     (in_token),
    .token_ok  (token_ok),
    .exp_bytes (exp_bytes)
  );

  td_status_calc i_status_calc (
    .ctrl      (in_ctrl),
    .res       (res),
    .token_ok  (token_ok),
    .exp_bytes (exp_bytes),
    .nxt_ctrl  (calc_ctrl),
    .evt       (calc_evt)
  );

  // next state
  always_comb begin
    valid_d = in_valid;
    ctrl_d  = in_valid ? calc_ctrl : ctrl_q;
    evt_d   = in_valid ? calc_evt : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      ctrl_q  <= '0;
      evt_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ctrl_q  <= ctrl_d;
      evt_q   <= evt_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_ctrl     = ctrl_q;
  assign ev_done      = evt_q.done;
  assign ev_err       = evt_q.err;
  assign ev_short     = evt_q.short_pkt;
  assign ev_token_bad = evt_q.token_bad;

  AST_EVENTS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_done || ev_err || ev_short || ev_token_bad) |-> out_valid); // R11
  AST_INACTIVE_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ctrl[B_ACT] && !$past(in_ctrl[B_ACT]))
      |-> (out_ctrl == $past(in_ctrl) && !ev_done && !ev_err && !ev_short && !ev_token_bad)); // R2
  AST_TOKEN_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_token_bad |-> (out_ctrl == $past(in_ctrl))); // R3
  AST_ACTIVE_NO_RETIRE_EVT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ctrl[B_ACT]) |-> (!ev_done && !ev_err && !ev_short)); // R7
  AST_ALLOW_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_ctrl[B_ALW_HI:B_ALW_LO] <= $past(in_ctrl[B_ALW_HI:B_ALW_LO]))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!out_valid && $past(!in_valid)) |-> $stable(out_ctrl)); // R11
endmodule

// File: tb/test_td_status_updater.sv
module test_td_status_updater;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RANDOM   = 3000;
  localparam int  WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_ctrl, in_token;
  logic [10:0] res_nbytes;
  logic        res_is_in, res_nak, res_stall, res_crc, res_bitstuff, res_babble, res_buferr;
  logic        out_valid;
  logic [31:0] out_ctrl;
  logic        ev_done, ev_err, ev_short, ev_token_bad;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  td_status_updater i_td_status_updater (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl), .in_token(in_token),
    .res_nbytes(res_nbytes), .res_is_in(res_is_in), .res_nak(res_nak), .res_stall(res_stall),
    .res_crc(res_crc), .res_bitstuff(res_bitstuff), .res_babble(res_babble),
    .res_buferr(res_buferr), .out_valid(out_valid), .out_ctrl(out_ctrl), .ev_done(ev_done),
    .ev_err(ev_err), .ev_short(ev_short), .ev_token_bad(ev_token_bad)
  );

  // expected {ctrl, done, err, short, token_bad}
  function automatic logic [35:0] expect_of(logic [31:0] c0, logic [31:0] tk, logic [10:0] n,
      logic isin, logic nak, logic stall, logic crc, logic bst, logic bab, logic bfe);
    logic [31:0] c = c0;
    logic [10:0] code = tk[31:21];
    logic [7:0]  id = tk[7:0];
    logic [10:0] want;
    logic [1:0]  alw = c0[28:27];
    bit fault = 0, clean = 0, shrt = 0;
    if (!c0[23]) return {c0, 4'b0000};
    if (!((id == 8'h2D || id == 8'h69 || id == 8'hE1) && (code <= 11'h4FF || code == 11'h7FF)))
      return {c0, 4'b0001};
    if (stall) begin c[22] = 1; fault = 1; end
    else if (bab) begin c[20] = 1; fault = 1; end
    else if (bfe) begin c[21] = 1; fault = 1; end
    else if (crc || bst) begin
      if (crc) c[18] = 1;
      if (bst) c[17] = 1;
      if (alw != 0) begin
        c[28:27] = alw - 2'd1;
        if (alw == 2'd1) begin c[22] = 1; fault = 1; end
      end
    end else if (nak) c[19] = 1;
    else begin
      c[10:0] = n - 11'd1;
      clean = 1;
      want = code + 11'd1;
      shrt = isin && c0[29] && (n < want);
    end
    if (fault || clean) c[23] = 0;
    return {c, (fault || clean) && c0[24], fault, shrt, 1'b0};
  endfunction

  function automatic string tag_of(logic [31:0] c0, logic [35:0] e, logic nak, logic stall,
      logic crc, logic bst, logic bab, logic bfe);
    int nf = int'(nak) + int'(stall) + int'(crc || bst) + int'(bab) + int'(bfe);
    if (!c0[23]) return "R2";
    if (e[0]) return "R3";
    if (nf > 1) return "R10";
    if (stall || bab || bfe) return "R9";
    if (crc || bst) return "R8";
    if (nak) return "R7";
    if (e[1]) return "R6";
    if (e[3]) return "R5";
    return "R4";
  endfunction

  task automatic check(string tag, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got ctrl=%h evt=%b expected ctrl=%h evt=%b",
               tag, got[35:4], got[3:0], exp[35:4], exp[3:0]);
    end
  endtask

  task automatic run(string tag_hint, logic [31:0] c0, logic [31:0] tk, logic [10:0] n,
      logic isin, logic nak, logic stall, logic crc, logic bst, logic bab, logic bfe);
    logic [35:0] e;
    string tag;
    @(negedge clk);
    in_valid = 1; in_ctrl = c0; in_token = tk; res_nbytes = n; res_is_in = isin;
    res_nak = nak; res_stall = stall; res_crc = crc; res_bitstuff = bst;
    res_babble = bab; res_buferr = bfe;
    e = expect_of(c0, tk, n, isin, nak, stall, crc, bst, bab, bfe);
    tag = (tag_hint != "") ? tag_hint : tag_of(c0, e, nak, stall, crc, bst, bab, bfe);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check(tag, {out_ctrl, ev_done, ev_err, ev_short, ev_token_bad}, e);
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R11 out_valid got %b expected 1", out_valid);
    end
  endtask

  function automatic logic [31:0] tok(logic [10:0] code, logic [7:0] id);
    return {code, 1'b0, 4'h3, 7'h11, 1'b0, id};
  endfunction

  // control word helper: active, allowance, ioc, spd
  function automatic logic [31:0] cw(logic act, logic [1:0] alw, logic ioc, logic spd);
    logic [31:0] c = 32'h0000_0123;
    c[23] = act; c[28:27] = alw; c[24] = ioc; c[29] = spd;
    return c;
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] held;
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; in_ctrl = 0; in_token = 0; res_nbytes = 0; res_is_in = 0;
    res_nak = 0; res_stall = 0; res_crc = 0; res_bitstuff = 0; res_babble = 0; res_buferr = 0;
    repeat (3) @(negedge clk);
    check("R1", {out_ctrl, ev_done, ev_err, ev_short, ev_token_bad}, 36'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", {out_ctrl, out_valid, ev_done, ev_err, ev_short}, 36'h0);

    // success, length encoding
    run("R4", cw(1, 2'd3, 0, 0), tok(11'd7, 8'hE1), 11'd8, 0, 0,0,0,0,0,0);
    run("R4", cw(1, 2'd3, 0, 0), tok(11'd7, 8'hE1), 11'd0, 0, 0,0,0,0,0,0);
    run("R5", cw(1, 2'd2, 1, 0), tok(11'd7, 8'h2D), 11'd8, 0, 0,0,0,0,0,0);
    // short packet
    run("R6", cw(1, 2'd3, 0, 1), tok(11'd63, 8'h69), 11'd10, 1, 0,0,0,0,0,0);
    run("R6", cw(1, 2'd3, 0, 1), tok(11'd63, 8'h69), 11'd64, 1, 0,0,0,0,0,0);
    run("R6", cw(1, 2'd3, 0, 1), tok(11'h7FF, 8'h69), 11'd0, 1, 0,0,0,0,0,0);
    run("R6", cw(1, 2'd3, 0, 1), tok(11'd63, 8'hE1), 11'd10, 0, 0,0,0,0,0,0);
    // token legality
    run("R3", cw(1, 2'd3, 1, 0), tok(11'd7, 8'h55), 11'd8, 0, 0,0,0,0,0,0);
    run("R3", cw(1, 2'd3, 1, 0), tok(11'h500, 8'h69), 11'd8, 1, 0,0,0,0,0,0);
    run("R3", cw(1, 2'd3, 1, 0), tok(11'h4FF, 8'h69), 11'd8, 1, 0,0,0,0,0,0);
    // NAK and retry allowance
    run("R7", cw(1, 2'd3, 1, 0), tok(11'd7, 8'h69), 11'd0, 1, 1,0,0,0,0,0);
    run("R8", cw(1, 2'd3, 1, 0), tok(11'd7, 8'h69), 11'd0, 1, 0,0,1,0,0,0);
    run("R8", cw(1, 2'd1, 1, 0), tok(11'd7, 8'h69), 11'd0, 1, 0,0,0,1,0,0);
    run("R8", cw(1, 2'd0, 1, 0), tok(11'd7, 8'h69), 11'd0, 1, 0,0,1,1,0,0);
    // hard faults and priority
    run("R9", cw(1, 2'd3, 1, 0), tok(11'd7, 8'h69), 11'd3, 1, 0,1,0,0,0,0);
    run("R9", cw(1, 2'd3, 0, 0), tok(11'd7, 8'h69), 11'd3, 1, 0,0,0,0,1,0);
    run("R9", cw(1, 2'd3, 0, 0), tok(11'd7, 8'hE1), 11'd3, 0, 0,0,0,0,0,1);
    run("R10", cw(1, 2'd1, 1, 0), tok(11'd7, 8'h69), 11'd3, 1, 1,1,1,1,1,1);
    run("R10", cw(1, 2'd1, 0, 0), tok(11'd7, 8'h69), 11'd3, 1, 1,0,1,0,0,1);
    run("R10", cw(1, 2'd2, 0, 0), tok(11'd7, 8'h69), 11'd3, 1, 1,0,1,0,0,0);
    // inactive pass-through
    run("R2", cw(0, 2'd1, 1, 1), tok(11'd7, 8'h55), 11'd3, 1, 0,1,1,0,1,0);

    // hold while idle with changing inputs
    held = out_ctrl;
    @(negedge clk);
    in_ctrl = 32'hFFFF_FFFF; in_token = tok(11'd1, 8'h69); res_stall = 1;
    @(posedge clk);
    @(negedge clk);
    check("R11", {out_ctrl, ev_done, ev_err, ev_short, ev_token_bad}, {held, 4'b0000});

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] c = $urandom;
      logic [31:0] t = $urandom;
      logic [10:0] code;
      logic [10:0] n;
      c[23] = ($urandom_range(0, 99) < 85);
      case ($urandom_range(0, 9))
        0: code = 11'h7FF;
        1: code = 11'(32'h500 + $urandom_range(0, 32'h2FE));
        default: code = 11'($urandom_range(0, 32'h4FF));
      endcase
      t[31:21] = code;
      if ($urandom_range(0, 9) != 0) begin
        case ($urandom_range(0, 2))
          0: t[7:0] = 8'h2D;
          1: t[7:0] = 8'h69;
          default: t[7:0] = 8'hE1;
        endcase
      end
      n = 11'($urandom_range(0, 32'h500));
      if ($urandom_range(0, 1) == 1) n = code + 11'd1;
      run("", c, t, n, 1'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 11) == 0,
          $urandom_range(0, 7) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 13) == 0,
          $urandom_range(0, 13) == 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule